// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block steps a single converter through a contiguous window of up to sixteen multiplexed analog inputs. Software programs it through a 16-bit write port that carries four targets: a scan window (first and last channel), a per-channel front-end setting, a control word and a conversion strobe. Each conversion is launched by one of three trigger sources (the write strobe, a pacer tick, or a rising edge on an external trigger line), each gated by its own enable bit.

For every conversion the block presents the channel number and that channel's gain code, unipolar flag and differential flag to the analog front end, pulses the converter start line, waits for the converter's done signal, and pushes a 16-bit word into a downstream FIFO whose top four bits name the channel the result came from. A channel set to differential consumes its odd neighbour, so the scan moves on by two. A trigger that arrives while a conversion is pending is dropped and recorded in a sticky overrun flag.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the scan window is channel 0 to channel 0, every channel setting is zero (gain 0, bipolar, single-ended), only the write-strobe trigger source is enabled, and adc_start, fifo_push, overrun and clk_sel are low.
- R2: A write with wr_sel=2 sets the first channel from wr_data[3:0] and the last channel from wr_data[11:8] and restarts the scan at the first channel; mux_chan shows that channel in the cycle after the write when idle.
- R3: A write with wr_sel=1 stores, for the channel in the first-channel field, differential from wr_data[5], unipolar from wr_data[4] and gain from wr_data[2:0]; the differential bit is discarded for an odd channel.
- R4: A control write (wr_sel=3) sets the source enables: wr_data[0] for the strobe (a write with wr_sel=0), wr_data[1] for pacer_tick, wr_data[2] for a rising edge of ext_trig. A disabled source produces no conversion.
- R5: A trigger accepted while idle makes adc_start high for exactly one cycle, starting the cycle after the trigger; from that cycle until adc_done, mux_chan, fe_gain, fe_unipolar and fe_diff show the converting channel's setting and do not change.
- R6: The cycle after adc_done is seen, fifo_push is high for one cycle with fifo_data = {channel[3:0], adc_data[11:0]}.
- R7: After a conversion the scan moves to channel+2 if the converted channel is differential, else channel+1; if that exceeds the last channel it returns to the first.
- R8: A trigger from any enabled source while a conversion is pending starts nothing and sets overrun, which stays high until the next control write clears it.
- R9: clk_sel follows bit 6 of the last control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write valid |
| wr_sel | input | 2 | Write target: 0 strobe, 1 channel setting, 2 scan window, 3 control |
| wr_data | input | 16 | Write data |
| pacer_tick | input | 1 | Pacer trigger, one pulse per tick |
| ext_trig | input | 1 | External trigger, rising edge active |
| adc_start | output | 1 | Converter start pulse |
| adc_done | input | 1 | Converter result valid |
| adc_data | input | 12 | Converter result |
| fifo_push | output | 1 | Sample write to downstream FIFO |
| fifo_data | output | 16 | Channel-tagged sample |
| mux_chan | output | 4 | Selected multiplexer channel |
| fe_gain | output | 3 | Gain code for the selected channel |
| fe_unipolar | output | 1 | Unipolar input range for the selected channel |
| fe_diff | output | 1 | Differential input for the selected channel |
| clk_sel | output | 1 | Counter clock select, 1 external |
| overrun | output | 1 | Sticky dropped-trigger flag |

## Verification
A corrupted scan position shows up as a wrong channel tag in the very next pushed sample and as a wrong mux_chan one cycle after that conversion finishes. A wrong stored channel setting appears on the front-end outputs on the same start cycle that launches that channel. A busy flag stuck high stops all further start pulses and raises overrun on the next trigger, while one stuck low lets a second start pulse through during a pending conversion; both are visible within a few cycles of a trigger.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

    typedef struct packed {
        logic       diff;
        logic       uni;
        logic [2:0] gain;
    } fe_cfg_t;

    typedef enum logic [1:0] {
        SEL_STROBE = 2'd0,
        SEL_CFG    = 2'd1,
        SEL_SPAN   = 2'd2,
        SEL_CTRL   = 2'd3
    } wr_sel_e;

    localparam int CFG_DIFF_BIT = 5;
    localparam int CFG_UNI_BIT  = 4;
    localparam int SPAN_HI_LSB  = 8;
    localparam int CTRL_CLK_BIT = 6;
    localparam int NUM_SRC      = 3;

    function automatic fe_cfg_t decode_cfg(input logic [15:0] w);
        fe_cfg_t c;
        c.diff = w[CFG_DIFF_BIT];
        c.uni  = w[CFG_UNI_BIT];
        c.gain = w[2:0];
        return c;
    endfunction

endpackage

// File: rtl/adc_cfg_table.sv
module adc_cfg_table
    import adc_scan_pkg::*;
#(
    parameter int NCH = 16,
    parameter int CW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CW-1:0]  wr_chan,
    input  fe_cfg_t        wr_cfg,
    input  logic [CW-1:0]  rd_chan,
    output fe_cfg_t        rd_cfg
);

    fe_cfg_t [NCH-1:0] mem_d, mem_q;
    fe_cfg_t           wr_clean;

    always_comb begin
        mem_d    = mem_q;
        wr_clean = wr_cfg;
        if (wr_chan[0]) begin
            wr_clean.diff = 1'b0;
        end
        if (wr_en) begin
            mem_d[wr_chan] = wr_clean;
        end
        rd_cfg = mem_d[rd_chan];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    // Odd entries never hold the differential flag (R3)
    for (genvar gi = 1; gi < NCH; gi += 2) begin : g_odd_chk
        assert_odd_no_diff_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !mem_q[gi].diff);
    end

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_strobe,
    input  logic               pacer_tick,
    input  logic               ext_trig,
    input  logic [NUM_SRC-1:0] src_en,
    output logic               fire
);

    typedef struct packed {
        logic ext_prev;
    } trig_st_t;

    trig_st_t st_d, st_q;
    logic [NUM_SRC-1:0] raw;

    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_trig;
        raw[0] = sw_strobe;
        raw[1] = pacer_tick;
        raw[2] = ext_trig & ~st_q.ext_prev;
        fire   = |(raw & src_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_ext_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_trig) && src_en[2] |-> fire);

    assert_fire_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (src_en != '0));

endmodule

// File: rtl/adc_scan_step.sv
module adc_scan_step #(
    parameter int CW = 4
) (
    input  logic [CW-1:0] cur,
    input  logic [CW-1:0] first,
    input  logic [CW-1:0] last,
    input  logic          diff,
    output logic [CW-1:0] nxt
);

    localparam logic [CW:0] STEP_ONE = (CW+1)'(1);
    localparam logic [CW:0] STEP_TWO = (CW+1)'(2);

    logic [CW:0] inc;

    always_comb begin
        inc = {1'b0, cur} + (diff ? STEP_TWO : STEP_ONE);
        nxt = (inc > {1'b0, last}) ? first : inc[CW-1:0];
    end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int DATA_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [15:0]                   wr_data,
    input  logic                          pacer_tick,
    input  logic                          ext_trig,
    output logic                          adc_start,
    input  logic                          adc_done,
    input  logic [DATA_W-1:0]             adc_data,
    output logic                          fifo_push,
    output logic [$clog2(NCH)+DATA_W-1:0] fifo_data,
    output logic [$clog2(NCH)-1:0]        mux_chan,
    output logic [2:0]                    fe_gain,
    output logic                          fe_unipolar,
    output logic                          fe_diff,
    output logic                          clk_sel,
    output logic                          overrun
);

    localparam int CW       = $clog2(NCH);
    localparam int SAMPLE_W = CW + DATA_W;

    typedef struct packed {
        logic [CW-1:0]       first;
        logic [CW-1:0]       last;
        logic [CW-1:0]       cur;
        logic [CW-1:0]       conv_chan;
        logic [CW-1:0]       fe_chan;
        logic [NUM_SRC-1:0]  src_en;
        logic                clk_sel;
        logic                busy;
        logic                rescan;
        logic                start;
        logic                push;
        logic                overrun;
        logic [SAMPLE_W-1:0] sample;
        fe_cfg_t             fe;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic    strobe_wr, cfg_wr, span_wr, ctrl_wr;
    logic    fire, launch;
    fe_cfg_t rd_cfg;
    logic [CW-1:0] step_nxt;
    logic    unused_bits;

    assign unused_bits = ^{wr_data[15:12], wr_data[7], wr_data[3]};

    always_comb begin
        strobe_wr = wr_en && (wr_sel == SEL_STROBE);
        cfg_wr    = wr_en && (wr_sel == SEL_CFG);
        span_wr   = wr_en && (wr_sel == SEL_SPAN);
        ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
    end

    adc_trig_sel u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_strobe  (strobe_wr),
        .pacer_tick (pacer_tick),
        .ext_trig   (ext_trig),
        .src_en     (st_q.src_en),
        .fire       (fire)
    );

    adc_cfg_table #(.NCH(NCH), .CW(CW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_chan (st_q.first),
        .wr_cfg  (decode_cfg(wr_data)),
        .rd_chan (st_d.cur),
        .rd_cfg  (rd_cfg)
    );

    adc_scan_step #(.CW(CW)) u_step (
        .cur   (st_q.conv_chan),
        .first (st_q.first),
        .last  (st_q.last),
        .diff  (st_q.fe.diff),
        .nxt   (step_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.push  = 1'b0;
        launch     = 1'b0;

        if (ctrl_wr) begin
            st_d.src_en  = wr_data[NUM_SRC-1:0];
            st_d.clk_sel = wr_data[CTRL_CLK_BIT];
            st_d.overrun = 1'b0;
        end

        if (st_q.busy) begin
            if (fire) begin
                st_d.overrun = 1'b1;
            end
            if (adc_done) begin
                st_d.busy   = 1'b0;
                st_d.push   = 1'b1;
                st_d.sample = {st_q.conv_chan, adc_data};
                st_d.cur    = st_q.rescan ? st_q.cur : step_nxt;
                st_d.rescan = 1'b0;
            end
        end else if (fire) begin
            st_d.busy  = 1'b1;
            st_d.start = 1'b1;
            launch     = 1'b1;
        end

        if (span_wr) begin
            st_d.first  = wr_data[CW-1:0];
            st_d.last   = wr_data[SPAN_HI_LSB +: CW];
            st_d.cur    = wr_data[CW-1:0];
            st_d.rescan = st_q.busy && !adc_done;
        end

        if (launch) begin
            st_d.conv_chan = st_d.cur;
        end

        if (!st_q.busy) begin
            st_d.fe      = rd_cfg;
            st_d.fe_chan = st_d.cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.src_en <= NUM_SRC'(1);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        adc_start   = st_q.start;
        fifo_push   = st_q.push;
        fifo_data   = st_q.sample;
        mux_chan    = st_q.fe_chan;
        fe_gain     = st_q.fe.gain;
        fe_unipolar = st_q.fe.uni;
        fe_diff     = st_q.fe.diff;
        clk_sel     = st_q.clk_sel;
        overrun     = st_q.overrun;
    end

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    assert_fe_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && $past(st_q.busy) |->
            $stable({mux_chan, fe_gain, fe_unipolar, fe_diff}));

    assert_no_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> !adc_start);

    assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && fire |=> overrun);

    assert_done_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && adc_done |=> fifo_push);

    assert_sample_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> fifo_data[DATA_W-1:0] == $past(adc_data));

    assert_sample_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> fifo_data[SAMPLE_W-1 -: CW] == $past(mux_chan));

endmodule

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pacer_tick = 1'b0;
    logic        ext_trig = 1'b0;
    logic        adc_start;
    logic        adc_done = 1'b0;
    logic [11:0] adc_data = 12'd0;
    logic        fifo_push;
    logic [15:0] fifo_data;
    logic [3:0]  mux_chan;
    logic [2:0]  fe_gain;
    logic        fe_unipolar;
    logic        fe_diff;
    logic        clk_sel;
    logic        overrun;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    logic [4:0] m_tab [16];
    int m_first, m_last, m_cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .adc_start(adc_start),
        .adc_done(adc_done), .adc_data(adc_data), .fifo_push(fifo_push),
        .fifo_data(fifo_data), .mux_chan(mux_chan), .fe_gain(fe_gain),
        .fe_unipolar(fe_unipolar), .fe_diff(fe_diff), .clk_sel(clk_sel),
        .overrun(overrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nxt_chan(input int c);
        int inc = c + (m_tab[c][4] ? 2 : 1);
        return (inc > m_last) ? m_first : inc;
    endfunction

    function automatic int fe_now();
        return {fe_diff, fe_unipolar, fe_gain};
    endfunction

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_span(input int f, input int l);
        wr(2'd2, 16'((l << 8) | f));
        m_first = f; m_last = l; m_cur = f;
        chk("R2 span first on mux", mux_chan, f);
    endtask

    task automatic set_cfg(input logic [15:0] v);
        wr(2'd1, v);
        m_tab[m_first] = {((m_first % 2) == 1) ? 1'b0 : v[5], v[4], v[2:0]};
    endtask

    task automatic conv(input int how, input logic [11:0] dv);
        int exp_ch = m_cur;
        int held;
        case (how)
            0: wr(2'd0, 16'h0);
            1: begin pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0; end
            default: begin ext_trig = 1'b1; @(negedge clk); end
        endcase
        chk("R5 start high", adc_start, 1);
        chk("R5 channel at start", mux_chan, exp_ch);
        chk("R5 setting at start", fe_now(), m_tab[exp_ch]);
        ext_trig = 1'b0;
        held = {mux_chan, fe_now()[4:0]};
        @(negedge clk);
        chk("R5 start one cycle", adc_start, 0);
        @(negedge clk);
        chk("R5 setting held", {mux_chan, fe_now()[4:0]}, held);
        adc_done = 1'b1; adc_data = dv;
        @(negedge clk);
        adc_done = 1'b0;
        chk("R6 push", fifo_push, 1);
        chk("R6 tagged sample", fifo_data, {exp_ch[3:0], dv});
        m_cur = nxt_chan(exp_ch);
        @(negedge clk);
        chk("R6 push one cycle", fifo_push, 0);
        chk("R7 next channel", mux_chan, m_cur);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !ended) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 16; i++) m_tab[i] = 5'd0;
        m_first = 0; m_last = 0; m_cur = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 adc_start", adc_start, 0);
        chk("R1 fifo_push", fifo_push, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 mux_chan", mux_chan, 0);
        chk("R1 setting", fe_now(), 0);
        pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
        chk("R1 pacer disabled after reset", adc_start, 0);
        ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
        chk("R1 ext disabled after reset", adc_start, 0);
        conv(0, 12'h5A3);

        // R9: clock select
        wr(2'd3, 16'h0041);
        chk("R9 clk_sel set", clk_sel, 1);
        wr(2'd3, 16'h0001);
        chk("R9 clk_sel clear", clk_sel, 0);

        // R3: settings, odd channel drops differential
        set_span(3, 3);
        set_cfg(16'h0037);
        chk("R3 odd no diff", fe_diff, 0);
        chk("R3 odd setting", fe_now(), 5'b01111);
        set_span(2, 2);
        set_cfg(16'h0025);
        chk("R3 even diff kept", fe_now(), 5'b10101);

        // R4: strobe disabled, pacer only
        wr(2'd3, 16'h0002);
        wr(2'd0, 16'h0);
        chk("R4 strobe ignored", adc_start, 0);
        @(negedge clk);
        chk("R4 strobe no push", fifo_push, 0);
        conv(1, 12'h111);
        wr(2'd3, 16'h0004);
        pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
        chk("R4 pacer ignored", adc_start, 0);
        conv(2, 12'h222);
        ext_trig = 1'b1; @(negedge clk);
        chk("R4 ext edge once", adc_start, 1);
        @(negedge clk);
        adc_done = 1'b1; adc_data = 12'h333; @(negedge clk); adc_done = 1'b0;
        m_cur = nxt_chan(m_cur);
        repeat (3) @(negedge clk);
        chk("R4 ext level no retrigger", adc_start, 0);
        ext_trig = 1'b0; @(negedge clk);

        // R7: stepping with a differential channel and wrap
        wr(2'd3, 16'h0007);
        set_span(4, 4); set_cfg(16'h0020);
        set_span(2, 2); set_cfg(16'h0000);
        set_span(2, 6);
        conv(0, 12'h001);
        chk("R7 plain step", mux_chan, 3);
        conv(0, 12'h002);
        conv(0, 12'h003);
        chk("R7 diff step by two", mux_chan, 6);
        conv(0, 12'h004);
        chk("R7 wrap to first", mux_chan, 2);

        // R8: overrun
        wr(2'd0, 16'h0);
        chk("R8 start", adc_start, 1);
        pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
        chk("R8 no second start", adc_start, 0);
        chk("R8 overrun set", overrun, 1);
        adc_done = 1'b1; adc_data = 12'hABC; @(negedge clk); adc_done = 1'b0;
        chk("R8 sample still pushed", fifo_data, {4'(m_cur), 12'hABC});
        m_cur = nxt_chan(m_cur);
        repeat (2) @(negedge clk);
        chk("R8 overrun sticky", overrun, 1);
        wr(2'd3, 16'h0007);
        chk("R8 overrun cleared", overrun, 0);

        // Random scans
        for (int it = 0; it < 30; it++) begin
            int f, l, n;
            for (int k = 0; k < 3; k++) begin
                int c = int'($urandom % 16);
                set_span(c, c);
                set_cfg(16'($urandom));
            end
            f = int'($urandom % 16);
            l = f + int'($urandom % (16 - f));
            set_span(f, l);
            n = 1 + int'($urandom % 6);
            for (int j = 0; j < n; j++) begin
                conv(int'($urandom % 3), 12'($urandom));
            end
        end
        chk("R8 no overrun in clean scans", overrun, 0);

        finish_run();
    end

endmodule